// File: doc/BRIEF.md
# Card Clock Divider Generator

This block derives the card-side clock of a memory-card host from the master clock. Software programs one control word through a single write strobe. The word holds an 8-bit divide value N, an enable, a bypass, a power-save bit and two bus-width selects. With bypass clear, the card clock runs at master/(2×(N+1)) with equal high and low phases, so the slowest rate is master/512. With bypass set, the master clock is passed straight through.

A power-save bit stops the card clock while the bus reports idle. The block also drives one-master-cycle edge strobes, so command and data logic can work in the master clock domain and never clock from the card clock. The bus-width selects are decoded into a mode code for the data path.

Changes to the divide value never cut a phase short. The phase in progress completes at its old length. Stopping, whether by clearing the enable or by power-save, always leaves the clock low after a full high phase.

Top module: `cardClkGen`

## Requirements
- R1: While reset is asserted and after its release (before any write), cardClk, riseStb and fallStb are 0 and busMode is 2'b00.
- R2: With enable set, bypass clear and power-save inactive, each high phase and each low phase of cardClk lasts exactly N+1 master cycles, giving a period of 2×(N+1).
- R3: With N = 255, each phase lasts 256 master cycles, so the period is 512 master cycles.
- R4: While enable and bypass are both set (and power-save is not stopping the clock), cardClk follows the master clock: it is 1 in the high half and 0 in the low half of every master cycle. riseStb and fallStb are both held at 1, and N has no effect.
- R5: When enable is cleared during a high phase, that high phase still completes its full length. cardClk then stays 0 and riseStb stays 0 until enable is set again.
- R6: A new N written during a phase does not change the length of that phase. It governs the phases that start after the next toggle.
- R7: With power-save set and busIdle high, cardClk finishes any high phase and then holds at 0. Toggling resumes once busIdle drops. With power-save clear, busIdle has no effect on cardClk.
- R8: In divided mode, riseStb is 1 for exactly the first master cycle of each cardClk high phase, and fallStb is 1 for exactly the first master cycle of each low phase. Neither is high otherwise.
- R9: busMode is 2'b01 when only the 4-bit select is set, 2'b10 whenever the 8-bit select is set (it wins over the 4-bit select), and 2'b00 when neither is set. busMode updates in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Write strobe for the control word |
| cfgDiv | input | DIV_W | Divide value N |
| cfgEnable | input | 1 | Card clock enable |
| cfgBypass | input | 1 | Pass master clock straight through |
| cfgPwrSave | input | 1 | Stop the clock while the bus is idle |
| cfgWide4 | input | 1 | Select 4-bit bus mode |
| cfgWide8 | input | 1 | Select 8-bit bus mode |
| busIdle | input | 1 | Bus has no transfer in progress |
| cardClk | output | 1 | Card clock |
| riseStb | output | 1 | Card clock rising-edge qualifier, one master cycle |
| fallStb | output | 1 | Card clock falling-edge qualifier, one master cycle |
| busMode | output | 2 | Decoded bus-width mode |

## Verification
The hardest cases to reach are writes that land inside a phase that is already running. A divide-value change or an enable clear must arrive after the rising edge but before the phase ends, so that the bench can tell a completed phase from a truncated one. To get there, the stimulus synchronises on riseStb and then issues the write in the next cycle. It then measures the remaining phase length against N+1 minus one. The same synchronisation places busIdle in the middle of a high phase for the power-save case. A behavioural phase model compares every output on every cycle, including through bypass entry and exit.

// File: rtl/cardClkGenPkg.sv
`timescale 1ns/1ps
package cardClkGenPkg;
  typedef enum logic [1:0] {
    BUS_1BIT = 2'b00,
    BUS_4BIT = 2'b01,
    BUS_8BIT = 2'b10
  } busMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;       // divider may start or continue toggling
    logic bypassOn;  // master clock routed to the card
  } ctlStb_t;
endpackage

// File: rtl/cardClkGenCtl.sv
`timescale 1ns/1ps
module cardClkGenCtl
  import cardClkGenPkg::*;
#(
  parameter int DIV_W     = 8,
  parameter bit HAS_WIDE8 = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgEnable,
  input  logic             cfgBypass,
  input  logic             cfgPwrSave,
  input  logic             cfgWide4,
  input  logic             cfgWide8,
  input  logic             busIdle,
  output ctlStb_t          ctlBus,
  output logic [DIV_W-1:0] shadowDiv,
  output busMode_e         busMode
);
  logic enQ, bypQ, psQ, w4Q, w8Eff, sleepNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowDiv <= '0;
      enQ       <= 1'b0;
      bypQ      <= 1'b0;
      psQ       <= 1'b0;
      w4Q       <= 1'b0;
    end else if (cfgWr) begin
      shadowDiv <= cfgDiv;
      enQ       <= cfgEnable;
      bypQ      <= cfgBypass;
      psQ       <= cfgPwrSave;
      w4Q       <= cfgWide4;
    end
  end

  generate
    if (HAS_WIDE8) begin : genWide8
      logic w8Q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      w8Q <= 1'b0;
        else if (cfgWr) w8Q <= cfgWide8;
      end
      assign w8Eff = w8Q;
    end else begin : genNoWide8
      logic unusedWide8;
      assign unusedWide8 = cfgWide8;
      assign w8Eff = 1'b0;
    end
  endgenerate

  assign sleepNow = psQ & busIdle;

  always_comb begin
    ctlBus.run      = enQ & ~bypQ & ~sleepNow;
    ctlBus.bypassOn = enQ &  bypQ & ~sleepNow;
    if (w8Eff)    busMode = BUS_8BIT;
    else if (w4Q) busMode = BUS_4BIT;
    else          busMode = BUS_1BIT;
  end
endmodule

// File: rtl/cardClkGenDp.sv
`timescale 1ns/1ps
module cardClkGenDp
  import cardClkGenPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          ctlBus,
  input  logic [DIV_W-1:0] shadowDiv,
  output logic             divLevel,
  output logic             cardClk,
  output logic             riseStb,
  output logic             fallStb
);
  logic [DIV_W-1:0] phaseCnt, activeDiv;
  logic riseQ, fallQ, halt, wrap;

  // a stop is only honoured while the divided clock is low
  assign halt = ~divLevel & ~ctlBus.run;
  assign wrap = (phaseCnt == activeDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      activeDiv <= '0;
      divLevel  <= 1'b0;
      riseQ     <= 1'b0;
      fallQ     <= 1'b0;
    end else if (halt) begin
      phaseCnt  <= '0;
      activeDiv <= shadowDiv;
      riseQ     <= 1'b0;
      fallQ     <= 1'b0;
    end else if (wrap) begin
      phaseCnt  <= '0;
      activeDiv <= shadowDiv;
      divLevel  <= ~divLevel;
      riseQ     <= ~divLevel;
      fallQ     <=  divLevel;
    end else begin
      phaseCnt  <= phaseCnt + 1'b1;
      riseQ     <= 1'b0;
      fallQ     <= 1'b0;
    end
  end

  assign cardClk = ctlBus.bypassOn ? clk  : divLevel;
  assign riseStb = ctlBus.bypassOn | riseQ;
  assign fallStb = ctlBus.bypassOn | fallQ;
endmodule

// File: rtl/cardClkGen.sv
`timescale 1ns/1ps
module cardClkGen
  import cardClkGenPkg::*;
#(
  parameter int DIV_W     = 8,
  parameter bit HAS_WIDE8 = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgEnable,
  input  logic             cfgBypass,
  input  logic             cfgPwrSave,
  input  logic             cfgWide4,
  input  logic             cfgWide8,
  input  logic             busIdle,
  output logic             cardClk,
  output logic             riseStb,
  output logic             fallStb,
  output logic [1:0]       busMode
);
  ctlStb_t          ctlBus;
  logic [DIV_W-1:0] shadowDiv;
  busMode_e         modeEnum;
  logic             divLevel;

  cardClkGenCtl #(.DIV_W(DIV_W), .HAS_WIDE8(HAS_WIDE8)) uCtl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgDiv(cfgDiv),
    .cfgEnable(cfgEnable), .cfgBypass(cfgBypass), .cfgPwrSave(cfgPwrSave),
    .cfgWide4(cfgWide4), .cfgWide8(cfgWide8), .busIdle(busIdle),
    .ctlBus(ctlBus), .shadowDiv(shadowDiv), .busMode(modeEnum)
  );

  cardClkGenDp #(.DIV_W(DIV_W)) uDp (
    .clk(clk), .rstN(rstN), .ctlBus(ctlBus), .shadowDiv(shadowDiv),
    .divLevel(divLevel), .cardClk(cardClk), .riseStb(riseStb), .fallStb(fallStb)
  );

  assign busMode = modeEnum;
endmodule

// File: rtl/cardClkGenChecker.sv
`timescale 1ns/1ps
module cardClkGenChecker #(
  parameter int DIV_W = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       riseStb,
  input logic       fallStb,
  input logic [1:0] busMode,
  input logic       runOn,
  input logic       bypassOn,
  input logic       divLevel
);
  int highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      highRun <= 0;
    else if (fallStb)               highRun <= 0;
    else if (riseStb)               highRun <= 1;
    else if (highRun != 0)          highRun <= highRun + 1;
  end

  assert_high_phase_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    highRun <= (1 << DIV_W));

  assert_bypass_strobes_R4: assert property (@(posedge clk) disable iff (!rstN)
    bypassOn |-> (riseStb && fallStb));

  assert_halt_stays_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!runOn && !bypassOn && !divLevel) |=> !divLevel);

  assert_rise_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (riseStb && !fallStb) |=> !riseStb || fallStb);

  assert_rise_marks_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (riseStb && !fallStb) |-> divLevel);

  assert_mode_legal_R9: assert property (@(posedge clk) disable iff (!rstN)
    busMode != 2'b11);
endmodule

bind cardClkGen cardClkGenChecker #(.DIV_W(DIV_W)) uChk (
  .clk(clk), .rstN(rstN), .riseStb(riseStb), .fallStb(fallStb),
  .busMode(busMode), .runOn(ctlBus.run), .bypassOn(ctlBus.bypassOn),
  .divLevel(divLevel)
);

// File: tb/cardClkGen_test.sv
`timescale 1ns/1ps
module cardClkGen_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWr = 0, cfgEnable = 0, cfgBypass = 0, cfgPwrSave = 0;
  logic cfgWide4 = 0, cfgWide8 = 0, busIdle = 0;
  logic [7:0] cfgDiv = 0;
  logic cardClk, riseStb, fallStb;
  logic [1:0] busMode;
  int nChecks = 0, nFail = 0;
  bit doneFlag = 0;

  always #4 clk = ~clk;

  cardClkGen uut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgDiv(cfgDiv),
    .cfgEnable(cfgEnable), .cfgBypass(cfgBypass), .cfgPwrSave(cfgPwrSave),
    .cfgWide4(cfgWide4), .cfgWide8(cfgWide8), .busIdle(busIdle),
    .cardClk(cardClk), .riseStb(riseStb), .fallStb(fallStb), .busMode(busMode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural phase model: level plus cycles left in the phase
  int mN = 0, mLeft = 1;
  bit mEn = 0, mByp = 0, mPs = 0, mW4 = 0, mW8 = 0, mLvl = 0, mRise = 0, mFall = 0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mN = 0; mEn = 0; mByp = 0; mPs = 0; mW4 = 0; mW8 = 0;
      mLvl = 0; mLeft = 1; mRise = 0; mFall = 0;
    end else begin
      bit going;
      going = mEn && !mByp && !(mPs && busIdle);
      mRise = 0; mFall = 0;
      if (!mLvl && !going) mLeft = mN + 1;
      else if (mLeft == 1) begin
        mLvl = !mLvl; mRise = mLvl; mFall = !mLvl; mLeft = mN + 1;
      end else mLeft = mLeft - 1;
      if (cfgWr) begin
        mN = cfgDiv; mEn = cfgEnable; mByp = cfgBypass; mPs = cfgPwrSave;
        mW4 = cfgWide4; mW8 = cfgWide8;
      end
    end
  end

  always @(posedge clk) begin
    #3;
    if (rstN && !doneFlag) begin
      bit byOn;
      int expMode;
      byOn = mEn && mByp && !(mPs && busIdle);
      expMode = mW8 ? 2 : (mW4 ? 1 : 0);
      chk(cardClk === (byOn ? 1'b1 : mLvl), "R2 model cardClk", cardClk, byOn ? 1 : mLvl);
      chk(riseStb === (byOn ? 1'b1 : mRise), "R8 model riseStb", riseStb, byOn ? 1 : mRise);
      chk(fallStb === (byOn ? 1'b1 : mFall), "R8 model fallStb", fallStb, byOn ? 1 : mFall);
      chk(busMode == expMode, "R9 model busMode", busMode, expMode);
    end
  end

  task automatic writeCfg(input int n, input bit en, input bit byp, input bit ps,
                          input bit w4, input bit w8);
    cfgDiv = n[7:0]; cfgEnable = en; cfgBypass = byp; cfgPwrSave = ps;
    cfgWide4 = w4; cfgWide8 = w8; cfgWr = 1;
    @(posedge clk); #3;
    cfgWr = 0;
  endtask

  task automatic waitRise();
    while (!(riseStb && !fallStb)) begin @(posedge clk); #3; end
  endtask

  task automatic phaseLen(output int n);
    logic lv;
    lv = cardClk; n = 1;
    forever begin
      @(posedge clk); #3;
      if (cardClk !== lv) break;
      n++;
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int len, bad;
    #20;
    chk(cardClk === 0, "R1 reset cardClk", cardClk, 0);
    chk(riseStb === 0 && fallStb === 0, "R1 reset strobes", riseStb + fallStb, 0);
    chk(busMode === 2'b00, "R1 reset busMode", busMode, 0);
    @(negedge clk); rstN = 1;
    @(posedge clk); #3;
    chk(cardClk === 0 && riseStb === 0, "R1 after release", cardClk, 0);

    // R2 basic divide by 8
    writeCfg(3, 1, 0, 0, 0, 0);
    waitRise();
    phaseLen(len); chk(len == 4, "R2 high phase", len, 4);
    phaseLen(len); chk(len == 4, "R2 low phase", len, 4);
    phaseLen(len); chk(len == 4, "R2 next high", len, 4);

    // R6 new N inside a running phase
    waitRise();
    writeCfg(1, 1, 0, 0, 0, 0);
    phaseLen(len); chk(len == 3, "R6 current phase keeps old N", len, 3);
    phaseLen(len); chk(len == 2, "R6 next low uses new N", len, 2);
    phaseLen(len); chk(len == 2, "R6 next high uses new N", len, 2);

    // R5 disable during high phase
    writeCfg(3, 1, 0, 0, 0, 0);
    waitRise();
    phaseLen(len);
    waitRise();
    writeCfg(3, 0, 0, 0, 0, 0);
    phaseLen(len); chk(len == 3, "R5 high completes", len, 3);
    bad = 0;
    repeat (20) begin
      if (cardClk !== 0 || riseStb !== 0) bad++;
      @(posedge clk); #3;
    end
    chk(bad == 0, "R5 held low while disabled", bad, 0);

    // R3 slowest rate
    writeCfg(255, 1, 0, 0, 0, 0);
    waitRise();
    phaseLen(len); chk(len == 256, "R3 high phase", len, 256);
    phaseLen(len); chk(len == 256, "R3 low phase", len, 256);

    // R4 bypass
    writeCfg(5, 1, 1, 0, 0, 0);
    repeat (3) begin
      chk(cardClk === 1 && riseStb === 1 && fallStb === 1, "R4 bypass high half",
          {cardClk, riseStb, fallStb}, 7);
      @(negedge clk); #3;
      chk(cardClk === 0, "R4 bypass low half", cardClk, 0);
      @(posedge clk); #3;
    end
    writeCfg(9, 1, 1, 0, 0, 0);
    @(negedge clk); #3;
    chk(cardClk === 0, "R4 N ignored low half", cardClk, 0);
    @(posedge clk); #3;
    chk(cardClk === 1, "R4 N ignored high half", cardClk, 1);

    // R7 power save
    writeCfg(2, 1, 0, 1, 0, 0);
    waitRise();
    busIdle = 1;
    @(posedge clk); #3;
    phaseLen(len); chk(len == 2, "R7 high completes before sleep", len, 2);
    bad = 0;
    repeat (15) begin
      if (cardClk !== 0 || riseStb !== 0) bad++;
      @(posedge clk); #3;
    end
    chk(bad == 0, "R7 clock stopped while idle", bad, 0);
    busIdle = 0;
    waitRise();
    phaseLen(len); chk(len == 3, "R7 resumes after idle", len, 3);
    writeCfg(2, 1, 0, 0, 0, 0);
    busIdle = 1;
    waitRise();
    phaseLen(len); chk(len == 3, "R7 idle ignored high", len, 3);
    phaseLen(len); chk(len == 3, "R7 idle ignored low", len, 3);
    busIdle = 0;

    // R9 bus mode decode
    writeCfg(2, 1, 0, 0, 1, 0); chk(busMode == 2'b01, "R9 4-bit", busMode, 1);
    writeCfg(2, 1, 0, 0, 1, 1); chk(busMode == 2'b10, "R9 both selects", busMode, 2);
    writeCfg(2, 1, 0, 0, 0, 1); chk(busMode == 2'b10, "R9 8-bit", busMode, 2);
    writeCfg(2, 1, 0, 0, 0, 0); chk(busMode == 2'b00, "R9 1-bit", busMode, 0);

    repeat (4) @(posedge clk);
    #3;
    finishRun();
  end
endmodule